// File: doc/BRIEF.md
# RAM Chip-Enable Write-Protect Gate

This block sits in the chip-enable path of a battery-backed RAM and blocks writes while the system reset is asserted. In normal operation the incoming active-low chip-enable goes straight through to the RAM. When reset asserts, the pass path closes and the RAM sees an inactive (high) chip-enable. A flag also turns on the output pull-up, so the RAM is held deselected.

A write that is in progress when reset arrives is allowed to finish. If the chip-enable is active (low) at that moment, closing is deferred. The gate closes when the chip-enable goes inactive, or when a grace window counted in timebase ticks runs out, whichever comes first. The gate reopens on the first clock edge after reset is released. The pass path is a combinational multiplexer, and a registered enable selects it. Analog transmission-gate effects and propagation delay are not modelled.

Top module: `ce_write_guard`

## Requirements
- R1: After the block reset `rst_n` is released, `gate_en` is 1 and `pullup_on` is 0.
- R2: While `gate_en` is 1, `ce_out_n` equals `ce_in_n` in the same cycle (combinational pass, low = RAM selected).
- R3: If the gate is open with no deferral pending, and a clock edge samples `sys_rst` = 1 (reset asserted) with `ce_in_n` = 1, then `gate_en` is 0 after that edge.
- R4: If the gate is open with no deferral pending, and a clock edge samples `sys_rst` = 1 with `ce_in_n` = 0, the gate stays open (deferral begins). It closes after the first later edge that samples `ce_in_n` = 1 while `sys_rst` is still 1.
- R5: During a deferral, the grace timer counts `tick_us` pulses sampled on the edges after the one that started the deferral. On the edge that samples the GRACE_TICKS-th pulse (default 15), the gate closes if it has not already closed.
- R6: Whenever `gate_en` is 0, `ce_out_n` is 1 and `pullup_on` is 1. Whenever `gate_en` is 1, `pullup_on` is 0.
- R7: Once closed, the gate stays closed on every edge that samples `sys_rst` = 1, whatever `ce_in_n` does.
- R8: After any edge that samples `sys_rst` = 0, `gate_en` is 1. This cancels a pending deferral and clears the grace timer.
- R9: Chip-enable activity while the gate is closed does not restart the grace timer or reopen the gate. A deferral that starts after a reopening gets the full GRACE_TICKS window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block's own flops |
| tick_us | input | 1 | One-cycle timebase pulse (one per microsecond) |
| sys_rst | input | 1 | System reset state, 1 = asserted |
| ce_in_n | input | 1 | Incoming chip-enable, active low |
| gate_en | output | 1 | Registered enable of the pass path |
| ce_out_n | output | 1 | Gated chip-enable to the RAM, active low |
| pullup_on | output | 1 | 1 turns on the output pull-up |

## Verification
The assertions assume that `sys_rst`, `ce_in_n` and `tick_us` are synchronous to `clk` and stable around each rising edge. They also assume that `tick_us` is a single-cycle pulse, so each sampled pulse counts as one grace step. The bench drives every input on the falling edge, and it issues ticks every fourth cycle from a free-running counter. A reset that starts during a write therefore spans several ticks, which exercises both how the grace window ends and how it is cancelled part-way.

// File: rtl/ceg_pkg.sv
package ceg_pkg;

  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_DEFER = 2'd1,
    GATE_SHUT  = 2'd2
  } gate_state_e;

  // True on the tick that completes the grace window.
  function automatic logic grace_hit(input int unsigned count,
                                     input int unsigned limit,
                                     input logic        tick);
    return tick && ((count + 1) == limit);
  endfunction

endpackage

// File: rtl/ceg_grace_timer.sv
module ceg_grace_timer #(
  parameter int unsigned GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  import ceg_pkg::*;

  localparam int unsigned CW = $clog2(GRACE_TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && grace_hit(int'(cnt_q), GRACE_TICKS, tick);

endmodule

// File: rtl/ceg_gate_ctrl.sv
module ceg_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic ce_in_n,
  input  logic expire,
  output logic gate_en,
  output logic hold_active
);
  import ceg_pkg::*;

  gate_state_e state_q, state_d;
  logic        gate_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_OPEN: begin
        if (sys_rst) state_d = ce_in_n ? GATE_SHUT : GATE_DEFER;
      end
      GATE_DEFER: begin
        if (!sys_rst)                state_d = GATE_OPEN;
        else if (ce_in_n || expire)  state_d = GATE_SHUT;
      end
      GATE_SHUT: begin
        if (!sys_rst) state_d = GATE_OPEN;
      end
      default: state_d = GATE_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= GATE_OPEN;
      gate_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      gate_q  <= (state_d != GATE_SHUT);
    end
  end

  assign gate_en     = gate_q;
  assign hold_active = (state_q == GATE_DEFER);

endmodule

// File: rtl/ceg_pass_mux.sv
module ceg_pass_mux (
  input  logic gate_en,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic pullup_on
);
  assign ce_out_n  = gate_en ? ce_in_n : 1'b1;
  assign pullup_on = ~gate_en;
endmodule

// File: rtl/ce_write_guard.sv
module ce_write_guard #(
  parameter int unsigned GRACE_TICKS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic sys_rst,
  input  logic ce_in_n,
  output logic gate_en,
  output logic ce_out_n,
  output logic pullup_on
);

  logic hold_active;
  logic grace_expire;

  ceg_grace_timer #(.GRACE_TICKS(GRACE_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (hold_active),
    .tick   (tick_us),
    .expire (grace_expire)
  );

  ceg_gate_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst     (sys_rst),
    .ce_in_n     (ce_in_n),
    .expire      (grace_expire),
    .gate_en     (gate_en),
    .hold_active (hold_active)
  );

  ceg_pass_mux u_mux (
    .gate_en   (gate_en),
    .ce_in_n   (ce_in_n),
    .ce_out_n  (ce_out_n),
    .pullup_on (pullup_on)
  );

endmodule

// File: rtl/ce_write_guard_chk.sv
module ce_write_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic sys_rst,
  input logic ce_in_n,
  input logic gate_en,
  input logic ce_out_n,
  input logic pullup_on,
  input logic hold_active,
  input logic grace_expire
);

  p_close_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !hold_active && sys_rst && ce_in_n) |=> !gate_en);

  p_defer_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !hold_active && sys_rst && !ce_in_n) |=> gate_en);

  p_release_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active && sys_rst && ce_in_n) |=> !gate_en);

  p_grace_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grace_expire && sys_rst) |=> !gate_en);

  p_pullup_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_on |-> ce_out_n);

  p_stay_shut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en && sys_rst) |=> !gate_en);

  p_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst |=> (gate_en && !hold_active));

endmodule

bind ce_write_guard ce_write_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sys_rst      (sys_rst),
  .ce_in_n      (ce_in_n),
  .gate_en      (gate_en),
  .ce_out_n     (ce_out_n),
  .pullup_on    (pullup_on),
  .hold_active  (hold_active),
  .grace_expire (grace_expire)
);

// File: tb/sim_ce_write_guard.sv
`timescale 1ns/1ps
module sim_ce_write_guard;

  localparam int GT = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b0;
  logic sys_rst = 1'b0;
  logic ce_in_n = 1'b1;
  logic gate_en, ce_out_n, pullup_on;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ce_write_guard #(.GRACE_TICKS(GT)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .sys_rst(sys_rst),
    .ce_in_n(ce_in_n), .gate_en(gate_en), .ce_out_n(ce_out_n),
    .pullup_on(pullup_on)
  );

  // Timebase: one tick every fourth cycle.
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt    <= tcnt + 1;
    tick_us <= ((tcnt % 4) == 3);
  end

  // Behavioural reference: mode 0 open, 1 deferring, 2 shut.
  int  m_mode = 0;
  int  m_ticks = 0;
  bit  m_en = 1;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_ticks = 0;
    end else if (!sys_rst) begin
      m_mode = 0; m_ticks = 0;
    end else if (m_mode == 0) begin
      m_mode  = ce_in_n ? 2 : 1;
      m_ticks = 0;
    end else if (m_mode == 1) begin
      if (ce_in_n) m_mode = 2;
      else if (tick_us) begin
        m_ticks++;
        if (m_ticks >= GT) m_mode = 2;
      end
    end
    m_en = (m_mode != 2);
  end

  task automatic chk(string rq, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Compare with the reference every cycle, away from the edges.
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(cur_req, gate_en, m_en, "gate_en");
      chk("R6", pullup_on, !m_en, "pullup_on");
      chk(m_en ? "R2" : "R6", ce_out_n, m_en ? ce_in_n : 1'b1, "ce_out_n");
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    #2;
    chk("R1", gate_en, 1'b1, "gate_en after reset");
    chk("R1", pullup_on, 1'b0, "pullup_on after reset");

    // R2: open pass of several patterns
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      cyc(1); ce_in_n = i[0] ^ i[2];
    end
    cyc(2); ce_in_n = 1'b1; cyc(1);

    // R3: reset while idle closes at once; R7/R9 closed stays closed
    sys_rst = 1'b1; cur_req = "R3";
    cyc(1);
    #2 chk("R3", gate_en, 1'b0, "close while idle");
    cur_req = "R7";
    cyc(1); ce_in_n = 1'b0; cyc(3); ce_in_n = 1'b1; cyc(2);
    cur_req = "R9";
    ce_in_n = 1'b0; cyc(70);
    #2 chk("R9", gate_en, 1'b0, "no reopen on ce activity");
    cyc(1); ce_in_n = 1'b1; sys_rst = 1'b0; cur_req = "R8";
    cyc(1);
    #2 chk("R8", gate_en, 1'b1, "reopen after release");
    cyc(2);

    // R4: reset during write, released by chip-enable going high
    ce_in_n = 1'b0; cyc(2);
    sys_rst = 1'b1; cur_req = "R4";
    cyc(5);
    #2 chk("R4", gate_en, 1'b1, "deferred during write");
    cyc(1); ce_in_n = 1'b1;
    cyc(1);
    #2 chk("R4", gate_en, 1'b0, "close on ce release");
    cur_req = "R7"; cyc(4);
    sys_rst = 1'b0; cur_req = "R8"; cyc(3);

    // R5: write held through reset, grace window ends it
    ce_in_n = 1'b0; cyc(2);
    sys_rst = 1'b1; cur_req = "R5";
    cyc(40);
    #2 chk("R5", gate_en, 1'b1, "open inside grace window");
    cyc(40);
    #2 chk("R5", gate_en, 1'b0, "closed after grace window");
    cyc(1); ce_in_n = 1'b1; cyc(2);
    sys_rst = 1'b0; cur_req = "R8"; cyc(3);

    // R8 cancel mid-deferral, then R9 fresh full window
    ce_in_n = 1'b0; cyc(1);
    sys_rst = 1'b1; cur_req = "R8";
    cyc(30);
    sys_rst = 1'b0; cyc(2);
    #2 chk("R8", gate_en, 1'b1, "deferral cancelled");
    cyc(1);
    sys_rst = 1'b1; cur_req = "R9";
    cyc(50);
    #2 chk("R9", gate_en, 1'b1, "full window after restart");
    cyc(30);
    #2 chk("R9", gate_en, 1'b0, "window expired");
    cyc(1); ce_in_n = 1'b1; sys_rst = 1'b0; cur_req = "R8";
    cyc(4);
    finish_run();
  end

endmodule